// File: doc/BRIEF.md
# Floating-Point Register-Form Instruction Decoder

This block takes one 32-bit instruction word from the floating-point register-to-register group and splits it into the pieces an execution pipeline needs. The outputs are a one-hot operation select, a precision flag, a compare condition and three operand descriptors. For single-precision forms each operand is one 32-bit register. For double-precision forms each operand is a pair of 32-bit registers. The pair is named by the 5-bit register field plus a per-operand offset flag. The flag decides whether the second half of the pair is the next register or the one after it.

The decode itself is combinational. One register stage sits at the output: a word presented with `in_valid` high appears on the outputs one clock later with `out_valid` high. A word is reported as illegal in three cases: its top six bits do not match the configured major opcode, its low byte is not an assigned sub-opcode, or a bit that the form requires to be zero is set. An illegal word carries no operation select and no condition.

Top module: `fpu_rr_decoder`

## Requirements
- R1: Sub-opcodes 0x00 to 0x07 decode to add, subtract, multiply, divide, int-to-float, float-to-int, remainder and multiply-add, which drive `out_sel` bits 0 to 7 in that order.
- R2: Sub-opcodes 0x08 to 0x0d are ordered compares. They drive `out_sel` bit 8, with `out_cond` = 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le.
- R3: Sub-opcodes 0x28 to 0x2d are unordered-or compares (`out_sel` bit 9, same `out_cond` order). Sub-opcode 0x2e is the pure unordered test (`out_sel` bit 10, `out_cond` 0).
- R4: Adding 0x10 to any code of R1 to R3 gives the double-precision form of the same operation, with `out_double` high.
- R5: Sub-opcode 0xd0 is the single custom operation and 0xe0 the double custom operation; both drive `out_sel` bit 11.
- R6: The destination, A and B register fields are bits 25:21, 20:16 and 15:11. Each operand's 6-bit index has the 5-bit field in bits 4:0. Bit 5 of the index is the operand's offset flag (bit 10, 9 and 8 for destination, A and B) in double forms, and 0 in single forms.
- R7: In double forms the second register of a pair is the field plus 2 when the flag is set and plus 1 when it is clear, modulo 32. In single forms it equals the field.
- R8: Single forms are illegal when any of bits 10:8 is set.
- R9: Double compares and double custom operations are illegal with bit 10 set. Double conversions are illegal with bit 8 set. Conversions are illegal with a nonzero B field. Compares are illegal with a nonzero destination field. Custom operations are illegal when bits 25:21 are nonzero.
- R10: An unassigned sub-opcode or a major opcode (bits 31:26) other than `MAJOR_OP` sets `out_illegal`. In that case `out_sel` and `out_cond` are zero.
- R11: Reset clears `out_valid`, `out_illegal` and `out_sel`. `out_valid` in each cycle equals `in_valid` from the cycle before, and results appear exactly one clock after the word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_illegal | output | 1 | Word is not a legal instruction of this group |
| out_double | output | 1 | Double-precision form |
| out_sel | output | 12 | One-hot operation select |
| out_cond | output | 3 | Compare condition |
| out_d_idx | output | 6 | Destination 6-bit index |
| out_d_lo | output | 5 | Destination first register |
| out_d_hi | output | 5 | Destination second register |
| out_a_idx | output | 6 | Source A 6-bit index |
| out_a_lo | output | 5 | Source A first register |
| out_a_hi | output | 5 | Source A second register |
| out_b_idx | output | 6 | Source B 6-bit index |
| out_b_lo | output | 5 | Source B first register |
| out_b_hi | output | 5 | Source B second register |

## Verification
The bench targets three kinds of corner case.

- Pair wraparound at registers 30 and 31 with the offset flag set. A decoder that dropped the modulo would send the second half to a wrong or out-of-range register.
- Reserved-bit rules that differ by form: bit 8 set on a double compare, bit 10 set on a double conversion, and bit 9 set on a single add. A decoder that applied one mask to every form would reject the legal words or accept the illegal ones.
- Codes that sit next to assigned ones, such as 0x0e, 0x2f, 0x40 and 0xd1, and a wrong major opcode. A decoder that matched only part of the byte would report a live operation there.

Latency is scored per item against the cycle it was issued, so an extra or missing register stage shows up even when the values are right.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    localparam int INSN_W  = 32;
    localparam int REG_W   = 5;
    localparam int IDX_W   = REG_W + 1;
    localparam int N_OPND  = 3;
    localparam int N_SEL   = 12;
    localparam int COND_W  = 3;

    localparam int SEL_ADD   = 0;
    localparam int SEL_SUB   = 1;
    localparam int SEL_MUL   = 2;
    localparam int SEL_DIV   = 3;
    localparam int SEL_I2F   = 4;
    localparam int SEL_F2I   = 5;
    localparam int SEL_REM   = 6;
    localparam int SEL_MADD  = 7;
    localparam int SEL_CMP   = 8;
    localparam int SEL_CMPU  = 9;
    localparam int SEL_UNORD = 10;
    localparam int SEL_CUST  = 11;

    localparam logic [7:0] CODE_CUST_S = 8'hd0;
    localparam logic [7:0] CODE_CUST_D = 8'he0;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GT = 3'd2,
        CC_GE = 3'd3,
        CC_LT = 3'd4,
        CC_LE = 3'd5
    } cmp_cond_e;

    typedef struct packed {
        logic              known;
        logic              dbl;
        logic [N_SEL-1:0]  sel;
        cmp_cond_e         cond;
    } opinfo_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] lo;
        logic [REG_W-1:0] hi;
    } operand_t;

    function automatic logic [REG_W-1:0] pair_second(input logic [REG_W-1:0] base,
                                                     input logic             far);
        return far ? REG_W'(base + REG_W'(2)) : REG_W'(base + REG_W'(1));
    endfunction

endpackage

// File: rtl/fpdec_opmap.sv
module fpdec_opmap
    import fpdec_pkg::*;
(
    input  logic [7:0] code,
    output opinfo_t    info
);
    logic [3:0] nib;
    logic       grp_u;
    logic       is_rr;

    assign nib   = code[3:0];
    assign grp_u = code[5];
    assign is_rr = (code[7:6] == 2'b00);

    always_comb begin
        info = '0;
        if (code == CODE_CUST_S) begin
            info.known          = 1'b1;
            info.sel[SEL_CUST]  = 1'b1;
        end else if (code == CODE_CUST_D) begin
            info.known          = 1'b1;
            info.dbl            = 1'b1;
            info.sel[SEL_CUST]  = 1'b1;
        end else if (is_rr) begin
            if (!grp_u) begin
                if (nib < 4'd8) begin
                    info.known    = 1'b1;
                    info.dbl      = code[4];
                    info.sel[nib] = 1'b1;
                end else if (nib <= 4'd13) begin
                    info.known         = 1'b1;
                    info.dbl           = code[4];
                    info.sel[SEL_CMP]  = 1'b1;
                    info.cond          = cmp_cond_e'(3'(nib - 4'd8));
                end
            end else begin
                if (nib >= 4'd8 && nib <= 4'd13) begin
                    info.known         = 1'b1;
                    info.dbl           = code[4];
                    info.sel[SEL_CMPU] = 1'b1;
                    info.cond          = cmp_cond_e'(3'(nib - 4'd8));
                end else if (nib == 4'd14) begin
                    info.known          = 1'b1;
                    info.dbl            = code[4];
                    info.sel[SEL_UNORD] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fpdec_operand.sv
module fpdec_operand
    import fpdec_pkg::*;
(
    input  logic [REG_W-1:0] field,
    input  logic             flag,
    input  logic             dbl,
    output operand_t         opnd
);
    logic far;

    assign far = dbl & flag;

    always_comb begin
        opnd.idx = {far, field};
        opnd.lo  = field;
        opnd.hi  = dbl ? pair_second(field, flag) : field;
    end

endmodule

// File: rtl/fpdec_rsvchk.sv
module fpdec_rsvchk
    import fpdec_pkg::*;
(
    input  logic             dbl,
    input  logic [N_SEL-1:0] sel,
    input  logic [2:0]       flags,
    input  logic [REG_W-1:0] d_field,
    input  logic [REG_W-1:0] b_field,
    output logic             bad
);
    logic is_conv, is_cmp, is_cust;
    logic bad_flags, bad_fields;

    assign is_conv = sel[SEL_I2F] | sel[SEL_F2I];
    assign is_cmp  = sel[SEL_CMP] | sel[SEL_CMPU] | sel[SEL_UNORD];
    assign is_cust = sel[SEL_CUST];

    always_comb begin
        if (!dbl) begin
            bad_flags = |flags;
        end else begin
            bad_flags = ((is_cmp | is_cust) & flags[2]) | (is_conv & flags[0]);
        end
        bad_fields = (is_conv & (|b_field))
                   | ((is_cmp | is_cust) & (|d_field));
    end

    assign bad = bad_flags | bad_fields;

endmodule

// File: rtl/fpu_rr_decoder.sv
module fpu_rr_decoder
    import fpdec_pkg::*;
#(
    parameter logic [5:0] MAJOR_OP = 6'h32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    output logic              out_valid,
    output logic              out_illegal,
    output logic              out_double,
    output logic [11:0]       out_sel,
    output logic [2:0]        out_cond,
    output logic [5:0]        out_d_idx,
    output logic [4:0]        out_d_lo,
    output logic [4:0]        out_d_hi,
    output logic [5:0]        out_a_idx,
    output logic [4:0]        out_a_lo,
    output logic [4:0]        out_a_hi,
    output logic [5:0]        out_b_idx,
    output logic [4:0]        out_b_lo,
    output logic [4:0]        out_b_hi
);
    localparam int FLAG_TOP  = 10;
    localparam int FIELD_TOP = 25;

    opinfo_t          info;
    operand_t         opnd [N_OPND];
    logic             rsv_bad;
    logic             illegal_c;
    logic             major_ok;

    assign major_ok = (in_insn[31:26] == MAJOR_OP);

    fpdec_opmap u_opmap (
        .code (in_insn[7:0]),
        .info (info)
    );

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        localparam int LSB  = FIELD_TOP - REG_W + 1 - REG_W * g;
        localparam int FPOS = FLAG_TOP - g;
        fpdec_operand u_opnd (
            .field (in_insn[LSB +: REG_W]),
            .flag  (in_insn[FPOS]),
            .dbl   (info.dbl),
            .opnd  (opnd[g])
        );
    end

    fpdec_rsvchk u_rsv (
        .dbl     (info.dbl),
        .sel     (info.sel),
        .flags   (in_insn[10:8]),
        .d_field (in_insn[25:21]),
        .b_field (in_insn[15:11]),
        .bad     (rsv_bad)
    );

    assign illegal_c = !major_ok | !info.known | rsv_bad;

    operand_t r_opnd [N_OPND];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_double  <= 1'b0;
            out_sel     <= '0;
            out_cond    <= '0;
            for (int i = 0; i < N_OPND; i++) r_opnd[i] <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= illegal_c;
                out_double  <= info.dbl;
                out_sel     <= illegal_c ? '0 : info.sel;
                out_cond    <= illegal_c ? '0 : info.cond;
                for (int i = 0; i < N_OPND; i++) r_opnd[i] <= opnd[i];
            end
        end
    end

    assign out_d_idx = r_opnd[0].idx;
    assign out_d_lo  = r_opnd[0].lo;
    assign out_d_hi  = r_opnd[0].hi;
    assign out_a_idx = r_opnd[1].idx;
    assign out_a_lo  = r_opnd[1].lo;
    assign out_a_hi  = r_opnd[1].hi;
    assign out_b_idx = r_opnd[2].idx;
    assign out_b_lo  = r_opnd[2].lo;
    assign out_b_hi  = r_opnd[2].hi;

    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_sel));

    a_r10_illegal_clears: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_sel == '0 && out_cond == '0));

    a_r10_legal_has_op: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal) |-> ($countones(out_sel) == 1));

    a_r2_cond_only_cmp: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cond != '0) |-> (out_sel[SEL_CMP] || out_sel[SEL_CMPU]));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r7_dst_pair: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_double) |->
            (out_d_hi == 5'(out_d_lo + (out_d_idx[5] ? 5'd2 : 5'd1))));

    a_r6_single_low_idx: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_double) |->
            (!out_d_idx[5] && !out_a_idx[5] && !out_b_idx[5] && out_a_hi == out_a_lo));

endmodule

// File: tb/test_fpu_rr_decoder.sv
`timescale 1ns/1ps
module test_fpu_rr_decoder;

    localparam logic [5:0] MAJ = 6'h32;

    typedef struct packed {
        logic        ill;
        logic        dbl;
        logic [11:0] sel;
        logic [2:0]  cond;
        logic [5:0]  di; logic [4:0] dl; logic [4:0] dh;
        logic [5:0]  ai; logic [4:0] al; logic [4:0] ah;
        logic [5:0]  bi; logic [4:0] bl; logic [4:0] bh;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic        out_valid, out_illegal, out_double;
    logic [11:0] out_sel;
    logic [2:0]  out_cond;
    logic [5:0]  out_d_idx, out_a_idx, out_b_idx;
    logic [4:0]  out_d_lo, out_d_hi, out_a_lo, out_a_hi, out_b_lo, out_b_hi;

    always #4 clk = ~clk;

    fpu_rr_decoder #(.MAJOR_OP(MAJ)) i_fpu_rr_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_double(out_double),
        .out_sel(out_sel), .out_cond(out_cond),
        .out_d_idx(out_d_idx), .out_d_lo(out_d_lo), .out_d_hi(out_d_hi),
        .out_a_idx(out_a_idx), .out_a_lo(out_a_lo), .out_a_hi(out_a_hi),
        .out_b_idx(out_b_idx), .out_b_lo(out_b_lo), .out_b_hi(out_b_hi)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    exp_t  q_exp [$];
    string q_tag [$];
    int    q_cyc [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(logic [5:0] maj, logic [4:0] d, logic [4:0] a,
                                       logic [4:0] b, logic [2:0] fl, logic [7:0] code);
        return {maj, d, a, b, fl, code};
    endfunction

    function automatic logic [15:0] opnd(logic [4:0] f, logic fl, logic dbl);
        logic [5:0] idx;
        logic [4:0] hi;
        idx = {dbl & fl, f};
        hi  = !dbl ? f : (fl ? 5'(f + 5'd2) : 5'(f + 5'd1));
        return {idx, f, hi};
    endfunction

    function automatic exp_t model(logic [31:0] w);
        exp_t        e;
        logic [7:0]  c;
        logic        known, dbl, conv, cmp, cust, rsv, ill;
        logic [11:0] s;
        logic [2:0]  cd;
        int          n;
        c = w[7:0]; known = 0; dbl = 0; s = '0; cd = '0;
        n = int'(c[3:0]);
        if (c == 8'hd0) begin known = 1; s[11] = 1; end
        else if (c == 8'he0) begin known = 1; s[11] = 1; dbl = 1; end
        else if (c[7:6] == 2'b00) begin
            if (!c[5]) begin
                if (n < 8) begin known = 1; s[n] = 1; end
                else if (n < 14) begin known = 1; s[8] = 1; cd = 3'(n - 8); end
            end else begin
                if (n >= 8 && n < 14) begin known = 1; s[9] = 1; cd = 3'(n - 8); end
                else if (n == 14) begin known = 1; s[10] = 1; end
            end
            if (known) dbl = c[4];
        end
        conv = s[4] | s[5];
        cmp  = s[8] | s[9] | s[10];
        cust = s[11];
        if (!dbl) rsv = |w[10:8];
        else      rsv = ((cmp | cust) & w[10]) | (conv & w[8]);
        if (conv && w[15:11] != 0) rsv = 1;
        if ((cmp || cust) && w[25:21] != 0) rsv = 1;
        ill = (w[31:26] != MAJ) || !known || rsv;
        e.ill  = ill;
        e.dbl  = dbl;
        e.sel  = ill ? '0 : s;
        e.cond = ill ? '0 : cd;
        {e.di, e.dl, e.dh} = opnd(w[25:21], w[10], dbl);
        {e.ai, e.al, e.ah} = opnd(w[20:16], w[9],  dbl);
        {e.bi, e.bl, e.bh} = opnd(w[15:11], w[8],  dbl);
        return e;
    endfunction

    task automatic send(input logic [31:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = w;
        q_exp.push_back(model(w));
        q_tag.push_back(tag);
        q_cyc.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_insn  = $urandom;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            exp_t  got, e;
            string t;
            int    c0;
            got = '{out_illegal, out_double, out_sel, out_cond,
                    out_d_idx, out_d_lo, out_d_hi, out_a_idx, out_a_lo, out_a_hi,
                    out_b_idx, out_b_lo, out_b_hi};
            total++;
            if (q_exp.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected output: got=%h expected=none", got);
            end else begin
                e = q_exp.pop_front(); t = q_tag.pop_front(); c0 = q_cyc.pop_front();
                if (got !== e) begin
                    bad++;
                    $display("FAIL %s: got=%h expected=%h", t, got, e);
                end
                total++;
                if (cyc != c0 + 1) begin
                    bad++;
                    $display("FAIL R11 latency for %s: got=%0d expected=%0d", t, cyc - c0, 1);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_sel !== '0) begin
            bad++;
            $display("FAIL R11 reset state: got=%b%b%h expected=000", out_valid, out_illegal, out_sel);
        end
        @(negedge clk); rst = 1'b0;

        // R1: single arithmetic, conversion and multiply-add codes
        for (int k = 0; k < 8; k++) begin
            logic [4:0] bf;
            bf = (k == 4 || k == 5) ? 5'd0 : 5'(k + 3);
            send(mk(MAJ, 5'(k + 1), 5'(k + 9), bf, 3'b000, 8'(k)), "R1 single op");
        end
        // R2: ordered compares
        for (int k = 8; k < 14; k++) send(mk(MAJ, 5'd0, 5'd4, 5'd7, 3'b000, 8'(k)), "R2 ordered cmp");
        // R3: unordered-or compares and pure unordered
        for (int k = 8'h28; k <= 8'h2e; k++) send(mk(MAJ, 5'd0, 5'd12, 5'd13, 3'b000, 8'(k)), "R3 unordered cmp");
        idle(2);
        // R4 / R6: double forms with flag combinations
        for (int k = 0; k < 8; k++) send(mk(MAJ, 5'd6, 5'd10, (k == 4 || k == 5) ? 5'd0 : 5'd20,
                                            (k == 4 || k == 5) ? 3'b110 : 3'(k), 8'(8'h10 + k)), "R4 double op");
        for (int k = 8'h18; k <= 8'h1d; k++) send(mk(MAJ, 5'd0, 5'd2, 5'd4, 3'b011, 8'(k)), "R4 double cmp");
        for (int k = 8'h38; k <= 8'h3e; k++) send(mk(MAJ, 5'd0, 5'd8, 5'd16, 3'b010, 8'(k)), "R4 double ucmp");
        // R5: custom
        send(mk(MAJ, 5'd0, 5'd3, 5'd5, 3'b000, 8'hd0), "R5 custom single");
        send(mk(MAJ, 5'd0, 5'd3, 5'd5, 3'b011, 8'he0), "R5 custom double");
        // R7: pair wraparound
        send(mk(MAJ, 5'd31, 5'd30, 5'd31, 3'b111, 8'h10), "R7 wrap flags set");
        send(mk(MAJ, 5'd31, 5'd30, 5'd29, 3'b000, 8'h12), "R7 wrap flags clear");
        send(mk(MAJ, 5'd17, 5'd30, 5'd0, 3'b010, 8'h14), "R7 itof pair");
        idle(1);
        // R8: single reserved bits
        send(mk(MAJ, 5'd1, 5'd2, 5'd3, 3'b010, 8'h00), "R8 single bit9");
        send(mk(MAJ, 5'd1, 5'd2, 5'd3, 3'b100, 8'h07), "R8 single bit10");
        send(mk(MAJ, 5'd0, 5'd2, 5'd3, 3'b001, 8'h08), "R8 single cmp bit8");
        // R9: form-specific rules
        send(mk(MAJ, 5'd0, 5'd2, 5'd3, 3'b100, 8'h18), "R9 double cmp bit10");
        send(mk(MAJ, 5'd0, 5'd2, 5'd3, 3'b001, 8'h3a), "R9 double cmp bit8 legal");
        send(mk(MAJ, 5'd4, 5'd2, 5'd0, 3'b001, 8'h15), "R9 double ftoi bit8");
        send(mk(MAJ, 5'd4, 5'd2, 5'd0, 3'b100, 8'h15), "R9 double ftoi bit10 legal");
        send(mk(MAJ, 5'd4, 5'd2, 5'd1, 3'b000, 8'h04), "R9 itof B nonzero");
        send(mk(MAJ, 5'd1, 5'd2, 5'd3, 3'b000, 8'h2b), "R9 cmp D nonzero");
        send(mk(MAJ, 5'd8, 5'd2, 5'd3, 3'b000, 8'hd0), "R9 custom D nonzero");
        send(mk(MAJ, 5'd0, 5'd2, 5'd3, 3'b100, 8'he0), "R9 custom double bit10");
        // R10: unassigned codes and wrong major
        send(mk(MAJ, 5'd0, 5'd1, 5'd1, 3'b000, 8'h0e), "R10 code 0e");
        send(mk(MAJ, 5'd0, 5'd1, 5'd1, 3'b000, 8'h2f), "R10 code 2f");
        send(mk(MAJ, 5'd0, 5'd1, 5'd1, 3'b000, 8'h40), "R10 code 40");
        send(mk(MAJ, 5'd0, 5'd1, 5'd1, 3'b000, 8'hd1), "R10 code d1");
        send(mk(MAJ, 5'd0, 5'd1, 5'd1, 3'b000, 8'h20), "R10 code 20");
        send(mk(6'h31, 5'd1, 5'd1, 5'd1, 3'b000, 8'h00), "R10 wrong major");
        idle(4);

        total++;
        if (q_exp.size() != 0) begin
            bad++;
            $display("FAIL R11 outputs missing: got=%0d expected=0", q_exp.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule